// File: doc/BRIEF.md
# Power-Fail Warning and Bus Protection Sequencer

This block sits between a host bus and a battery-backed memory. It watches two supply-status flags that an analog front end has already digitised. One flag says the supply has dropped under the deselect threshold. The other says it has dropped under the lower battery-switchover threshold. From these flags the block drives an open-drain warning line (pull-low request), a protection signal that cuts the host strobes off from the memory, and a battery-select signal.

When the supply sags, the warning goes out at once. Software then has a fixed window of internal clock cycles to finish its work before the memory is cut off. If the supply comes back inside that window, the warning is withdrawn and access is never interrupted. After a real cut-off, protection is kept for a programmed number of cycles after the supply flags clear. A write strobe that was active when protection began is not allowed to resume by itself. The host must release it and start a new write.

Both windows are parameters counted in clock cycles. The defaults (2500 and 100000) are 25 µs and 1 ms at 100 MHz.

Top module: `power_fail_seq`

## Requirements
- R1: After reset, alertPullDown, busProtected and batterySel are 0, and the gated strobes follow the host strobes as given in R11.
- R2: When the supply is seen as fallen (either flag 1) while the block is idle, alertPullDown goes to 1 one clock edge later.
- R3: If the supply stays fallen and the switchover flag stays 0, busProtected rises exactly WARN_CYCLES clock edges after alertPullDown rose.
- R4: If both flags are 0 at an edge during the warning window, alertPullDown falls at that edge and busProtected does not assert.
- R5: While busProtected is 1, memSel, memWr and memOe are all 0 whatever the host drives.
- R6: A host write that is active when busProtected rises has memWr forced to 0 in the same cycle in which busProtected becomes 1.
- R7: batterySel equals the switchover flag delayed by one edge. It is only ever 1 while busProtected is 1. A switchover flag of 1 seen while idle or during the warning window asserts busProtected at the next edge, without waiting for the window to end.
- R8: alertPullDown stays 1 while protected and the supply is fallen. At the first edge with both flags 0, alertPullDown falls. busProtected falls RECOVER_CYCLES edges after that first edge.
- R9: If either flag returns to 1 during the recovery hold, protection stays on. The full RECOVER_CYCLES hold restarts from the next edge that sees both flags at 0.
- R10: A host write strobe held at 1 across the end of protection keeps memWr at 0 until hostWr has been sampled 0 at an edge.
- R11: Outside protection, memSel = hostSel, memWr = hostSel AND hostWr (when re-armed), and memOe = hostSel AND hostOe AND NOT hostWr. All of these are combinational from the host pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| belowDeselect | input | 1 | Supply under the deselect threshold |
| belowSwitch | input | 1 | Supply under the battery-switchover threshold |
| hostSel | input | 1 | Host chip select, active high |
| hostWr | input | 1 | Host write strobe, active high |
| hostOe | input | 1 | Host output enable, active high |
| memSel | output | 1 | Gated select to the memory |
| memWr | output | 1 | Gated write strobe to the memory |
| memOe | output | 1 | Gated output enable; 0 puts the data bus in high impedance |
| alertPullDown | output | 1 | 1 pulls the open-drain warning line low, 0 releases it |
| busProtected | output | 1 | Memory deselected and write-protected |
| batterySel | output | 1 | Selects the battery as the supply |

## Verification
If the sequencer state is wrong, the warning line shows it first. The warning would rise late, stay high after an early recovery, or drop while the supply is still fallen, and any of these appears at the port within one edge. A wrong window counter shows up as busProtected changing one or more edges away from the exact WARN_CYCLES or RECOVER_CYCLES point, so the bench checks both sides of each boundary. A lost re-arm flag lets a stale write strobe through in the first cycle after protection lifts, so that cycle is checked on its own.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_WARN    = 2'd1,
    PH_HOLD    = 2'd2,
    PH_RECOVER = 2'd3
  } pfsPhase_t;

  typedef struct packed {
    logic blockBus;
    logic alert;
    logic battery;
  } pfsStrobe_t;

endpackage

// File: rtl/pfs_ctrl.sv
module pfs_ctrl
  import pfs_pkg::*;
#(
  parameter int WARN_CYCLES    = 2500,
  parameter int RECOVER_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       belowDeselect,
  input  logic       belowSwitch,
  output pfsStrobe_t strb
);

  localparam int MAX_WIN = (WARN_CYCLES > RECOVER_CYCLES) ? WARN_CYCLES : RECOVER_CYCLES;
  localparam int CW      = $clog2(MAX_WIN + 1);
  localparam logic [CW-1:0] WARN_LAST = CW'(WARN_CYCLES - 1);
  localparam logic [CW-1:0] REC_LAST  = CW'(RECOVER_CYCLES - 1);

  pfsPhase_t      phase, phaseNext;
  logic [CW-1:0]  winCnt, winCntNext;
  logic           batReg;
  logic           fallen;

  assign fallen = belowDeselect | belowSwitch;

  always_comb begin
    phaseNext  = phase;
    winCntNext = winCnt;
    unique case (phase)
      PH_IDLE: begin
        winCntNext = '0;
        if (belowSwitch)        phaseNext = PH_HOLD;
        else if (belowDeselect) phaseNext = PH_WARN;
      end
      PH_WARN: begin
        if (!fallen) begin
          phaseNext  = PH_IDLE;
          winCntNext = '0;
        end else if (belowSwitch || winCnt == WARN_LAST) begin
          phaseNext  = PH_HOLD;
          winCntNext = '0;
        end else begin
          winCntNext = winCnt + 1'b1;
        end
      end
      PH_HOLD: begin
        winCntNext = '0;
        if (!fallen) phaseNext = PH_RECOVER;
      end
      PH_RECOVER: begin
        if (fallen) begin
          phaseNext  = PH_HOLD;
          winCntNext = '0;
        end else if (winCnt == REC_LAST) begin
          phaseNext  = PH_IDLE;
          winCntNext = '0;
        end else begin
          winCntNext = winCnt + 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      winCnt <= '0;
      batReg <= 1'b0;
    end else begin
      phase  <= phaseNext;
      winCnt <= winCntNext;
      batReg <= belowSwitch;
    end
  end

  assign strb.blockBus = (phase == PH_HOLD) || (phase == PH_RECOVER);
  assign strb.alert    = (phase == PH_WARN) || (phase == PH_HOLD);
  assign strb.battery  = batReg;

  // R2
  alert_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && fallen) |=> strb.alert);

  // R4
  early_recover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WARN && !fallen) |=> (!strb.alert && !strb.blockBus));

  // R7
  battery_in_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.battery |-> strb.blockBus);

  // R8
  release_after_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.blockBus) |-> ($past(phase) == PH_RECOVER && !strb.alert));

  // R9
  redip_rehold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RECOVER && fallen) |=> (strb.blockBus && winCnt == '0));

endmodule

// File: rtl/pfs_gate.sv
module pfs_gate
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pfsStrobe_t strb,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic       hostOe,
  output logic       memSel,
  output logic       memWr,
  output logic       memOe,
  output logic       alertPullDown,
  output logic       busProtected,
  output logic       batterySel
);

  logic wrArmed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wrArmed <= 1'b1;
    else if (!hostWr)       wrArmed <= 1'b1;
    else if (strb.blockBus) wrArmed <= 1'b0;
  end

  assign memSel        = hostSel & ~strb.blockBus;
  assign memWr         = hostSel & hostWr & wrArmed & ~strb.blockBus;
  assign memOe         = hostSel & hostOe & ~hostWr & ~strb.blockBus;
  assign alertPullDown = strb.alert;
  assign busProtected  = strb.blockBus;
  assign batterySel    = strb.battery;

  // R5
  no_access_protected_chk: assert property (@(posedge clk) disable iff (!rstN)
    busProtected |-> (!memSel && !memWr && !memOe));

  // R10
  stale_write_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busProtected && hostWr) |=> !memWr);

  // R6
  write_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busProtected) |-> !memWr);

endmodule

// File: rtl/power_fail_seq.sv
module power_fail_seq
  import pfs_pkg::*;
#(
  parameter int WARN_CYCLES    = 2500,
  parameter int RECOVER_CYCLES = 100000
) (
  input  logic clk,
  input  logic rstN,
  input  logic belowDeselect,
  input  logic belowSwitch,
  input  logic hostSel,
  input  logic hostWr,
  input  logic hostOe,
  output logic memSel,
  output logic memWr,
  output logic memOe,
  output logic alertPullDown,
  output logic busProtected,
  output logic batterySel
);

  pfsStrobe_t strb;

  pfs_ctrl #(
    .WARN_CYCLES   (WARN_CYCLES),
    .RECOVER_CYCLES(RECOVER_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .belowDeselect(belowDeselect),
    .belowSwitch  (belowSwitch),
    .strb         (strb)
  );

  pfs_gate u_gate (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .hostSel      (hostSel),
    .hostWr       (hostWr),
    .hostOe       (hostOe),
    .memSel       (memSel),
    .memWr        (memWr),
    .memOe        (memOe),
    .alertPullDown(alertPullDown),
    .busProtected (busProtected),
    .batterySel   (batterySel)
  );

endmodule

// File: tb/power_fail_seq_bench.sv
module power_fail_seq_bench;

  localparam int W = 20;
  localparam int R = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic belowDeselect = 1'b0, belowSwitch = 1'b0;
  logic hostSel = 1'b0, hostWr = 1'b0, hostOe = 1'b0;
  logic memSel, memWr, memOe, alertPullDown, busProtected, batterySel;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  power_fail_seq #(.WARN_CYCLES(W), .RECOVER_CYCLES(R)) u_power_fail_seq (
    .clk(clk), .rstN(rstN), .belowDeselect(belowDeselect), .belowSwitch(belowSwitch),
    .hostSel(hostSel), .hostWr(hostWr), .hostOe(hostOe),
    .memSel(memSel), .memWr(memWr), .memOe(memOe),
    .alertPullDown(alertPullDown), .busProtected(busProtected), .batterySel(batterySel)
  );

  // behavioural reference: timers as integers, -1 meaning "not running"
  int  warnT = -1;
  int  recT  = -1;
  bit  mProt = 1'b0;
  bit  mBat  = 1'b0;
  bit  mArm  = 1'b1;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warnT = -1; recT = -1; mProt = 1'b0; mBat = 1'b0; mArm = 1'b1;
    end else begin
      bit down, wasProt;
      down    = belowDeselect || belowSwitch;
      wasProt = mProt;
      if (!hostWr) mArm = 1'b1;
      else if (wasProt) mArm = 1'b0;
      mBat = belowSwitch;
      if (!wasProt) begin
        if (warnT < 0) begin
          if (belowSwitch) mProt = 1'b1;
          else if (belowDeselect) warnT = 0;
        end else if (!down) warnT = -1;
        else if (belowSwitch) begin mProt = 1'b1; warnT = -1; end
        else begin
          warnT++;
          if (warnT == W) begin mProt = 1'b1; warnT = -1; end
        end
      end else begin
        if (recT < 0) begin
          if (!down) recT = 0;
        end else if (down) recT = -1;
        else begin
          recT++;
          if (recT == R) begin mProt = 1'b0; recT = -1; end
        end
      end
    end
  end

  task automatic expectBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always begin
    @(negedge clk);
    #2;
    if (rstN && !finished) begin
      bit eAlert;
      eAlert = (warnT >= 0) || (mProt && recT < 0);
      expectBit("R2 alertPullDown", alertPullDown, eAlert);
      expectBit("R3 busProtected", busProtected, mProt);
      expectBit("R7 batterySel", batterySel, mBat);
      expectBit("R5 memSel", memSel, hostSel && !mProt);
      expectBit("R6 memWr", memWr, hostSel && hostWr && mArm && !mProt);
      expectBit("R11 memOe", memOe, hostSel && hostOe && !hostWr && !mProt);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1: reset state
    expectBit("R1 alert", alertPullDown, 1'b0);
    expectBit("R1 protect", busProtected, 1'b0);
    expectBit("R1 battery", batterySel, 1'b0);

    // R11: pass-through patterns
    hostSel = 1; hostOe = 1; #1;
    expectBit("R11 read oe", memOe, 1'b1);
    hostWr = 1; #1;
    expectBit("R11 write", memWr, 1'b1);
    expectBit("R11 oe off in write", memOe, 1'b0);
    cyc(2);

    // R2/R3/R6: fall with a write in progress
    belowDeselect = 1;
    cyc(1);
    expectBit("R2 alert next edge", alertPullDown, 1'b1);
    cyc(W - 1);
    expectBit("R3 not yet protected", busProtected, 1'b0);
    expectBit("R3 write still open", memWr, 1'b1);
    cyc(1);
    expectBit("R3 protected at window end", busProtected, 1'b1);
    expectBit("R6 write truncated", memWr, 1'b0);
    expectBit("R5 select blocked", memSel, 1'b0);

    // R7: switchover
    belowSwitch = 1;
    cyc(1);
    expectBit("R7 battery on", batterySel, 1'b1);
    cyc(3);
    belowSwitch = 0;
    cyc(1);
    expectBit("R7 battery off", batterySel, 1'b0);

    // R8/R10: recovery, write held across release
    belowDeselect = 0;
    cyc(1);
    expectBit("R8 alert released", alertPullDown, 1'b0);
    cyc(R - 1);
    expectBit("R8 still held", busProtected, 1'b1);
    cyc(1);
    expectBit("R8 released", busProtected, 1'b0);
    expectBit("R10 stale write blocked", memWr, 1'b0);
    expectBit("R10 select back", memSel, 1'b1);
    hostWr = 0;
    cyc(1);
    hostWr = 1; #1;
    expectBit("R10 fresh write passes", memWr, 1'b1);
    cyc(1);
    hostWr = 0;

    // R4: recovery inside warning window
    belowDeselect = 1;
    cyc(5);
    expectBit("R4 alert in window", alertPullDown, 1'b1);
    belowDeselect = 0;
    cyc(1);
    expectBit("R4 alert withdrawn", alertPullDown, 1'b0);
    cyc(W + 2);
    expectBit("R4 never protected", busProtected, 1'b0);

    // R9: dip during recovery
    belowDeselect = 1;
    cyc(W + 1);
    expectBit("R9 protected", busProtected, 1'b1);
    belowDeselect = 0;
    cyc(R / 2);
    belowDeselect = 1;
    cyc(2);
    belowDeselect = 0;
    cyc(R);
    expectBit("R9 hold restarted", busProtected, 1'b1);
    cyc(1);
    expectBit("R9 released after full hold", busProtected, 1'b0);

    // R7: switchover from idle forces immediate protection
    hostWr = 0; hostOe = 1;
    belowDeselect = 1; belowSwitch = 1;
    cyc(1);
    expectBit("R7 immediate protect", busProtected, 1'b1);
    expectBit("R5 oe blocked", memOe, 1'b0);
    belowSwitch = 0; belowDeselect = 0;
    cyc(R + 3);
    expectBit("R8 idle again", busProtected, 1'b0);

    // R7: switchover during the warning window
    belowDeselect = 1;
    cyc(4);
    belowSwitch = 1;
    cyc(1);
    expectBit("R7 protect from window", busProtected, 1'b1);
    belowSwitch = 0; belowDeselect = 0;
    cyc(R + 3);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired at %0t: actual=running expected=done", $time);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule